// File: doc/BRIEF.md
# Cluster Power Request and Status Engine

This block is the register-mapped front end of a power controller serving two processor clusters. Software asks for an operating-point change on either cluster by writing a level index. It can also issue a packed command word that reads one word from a small internal table of operating-point values. Only one operation runs at a time. It lasts a fixed, parameterised number of cycles and then reports success or failure in one shared status word. The interrupt output stays high for as long as any status bit is set, and reading the status word clears it.

The same register space also holds the wake-interrupt mask and its raw and masked views, the power-down enable for each cluster, a 32-bit resume-address mailbox for each CPU, and a read-only view of which CPUs are idle in wait-for-interrupt. Reads are combinational on `rdata_o` in the cycle `re_i` is high. Writes take effect at the clock edge.

Top module: `pwrc_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and both power-down outputs are low.
- R2: A write to the cluster-A level register (0x00) starts request type 0, and a write to the cluster-B level register (0x08) starts type 1. The result lands exactly LATENCY cycles after the write edge. On success, status bit 4*t is set and the level register reads the new index from that point on; before that it reads the old index.
- R3: A level index of NUM_OPP or more ends after the same latency with status bit 4*t+1 set and bit 4*t clear, and the level register keeps its old value. Index NUM_OPP-1 succeeds.
- R4: A command word (0x10) with bit 31 set, function code 6 in bits 23:20 and a word offset in bits 19:0 inside [CFG_BASE, CFG_BASE+CFG_WORDS) completes as type 2 (status bit 8). Table word k = offset-CFG_BASE then appears at 0x74, with value ((900+10k)<<20) | (50000+5000k). Register 0x10 reads back the last command word written.
- R5: A command with the start bit set but another function code, or an offset outside the table, ends with status bit 9 and leaves 0x74 unchanged. A command without the start bit starts nothing.
- R6: `irq_o` is high exactly while the status word (0x18) is nonzero. A read of 0x18 returns the word and clears it, so `irq_o` falls unless a new bit is set in the same cycle.
- R7: A request written while an operation is running is rejected. The error bit of the rejected type is set at that write's edge. The running operation finishes with its own result and timing.
- R8: Bit 0 of 0x04, 0x0C and 0x14 reads 1 while a type 0, 1 or 2 operation is running, respectively. Bit 0 of 0x1C reads 1 while any operation runs.
- R9: The wake mask (0x24) holds bits 11:0: cluster-A CPU n at bit n, cluster-B CPU n at bit n+4, and 11:10 as the global wake enables. It drives `wake_mask_o`. 0x28 reads `wake_raw_i` and 0x2C reads raw AND mask.
- R10: The idle status at 0x3C reports cluster-A CPU n at bit n and cluster-B CPU n at bit 3+n.
- R11: The resume mailboxes at 0x68+4n (cluster A) and 0x78+4n (cluster B) are 32-bit read/write. Bit 0 of 0x30 and of 0x34 is read/write and drives `pd_en_a_o` and `pd_en_b_o`.
- R12: 0x70 is a 32-bit read/write data word. Writes to read-only or unmapped addresses change nothing, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (clears status on 0x18) |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| wake_raw_i | input | 12 | Raw wake-interrupt lines |
| wfi_a_i | input | N_CPU | Cluster-A CPUs idle in wait-for-interrupt |
| wfi_b_i | input | N_CPU | Cluster-B CPUs idle in wait-for-interrupt |
| irq_o | output | 1 | Level-high status interrupt |
| wake_mask_o | output | 12 | Wake-interrupt mask |
| pd_en_a_o | output | 1 | Cluster-A power-down enable |
| pd_en_b_o | output | 1 | Cluster-B power-down enable |

## Verification
The bench goes after the exact completion cycle. It checks that `irq_o` is still low one cycle before LATENCY and high at LATENCY, so an off-by-one counter shows up at once. It probes the operating-point limit from both sides (index NUM_OPP-1 and NUM_OPP) and the table window at its first word, its last word and one word outside each end. A design that compared with the wrong inequality would flip one of these results. A burst of a same-type request and a config request arriving while a level change runs must produce both error bits and the original success. A design that let a late request restart the counter or overwrite the pending result would show a missing completion bit or the wrong level.

// File: rtl/pwrc_pkg.sv
package pwrc_pkg;
  localparam int N_REQ = 3;
  localparam int ST_W  = 4 * N_REQ;

  typedef enum logic [1:0] {
    REQ_LVL_A = 2'd0,
    REQ_LVL_B = 2'd1,
    REQ_CFG   = 2'd2
  } req_t;

  localparam logic [7:0] A_LVL_A   = 8'h00;
  localparam logic [7:0] A_BSY_A   = 8'h04;
  localparam logic [7:0] A_LVL_B   = 8'h08;
  localparam logic [7:0] A_BSY_B   = 8'h0C;
  localparam logic [7:0] A_CMD     = 8'h10;
  localparam logic [7:0] A_BSY_CMD = 8'h14;
  localparam logic [7:0] A_STAT    = 8'h18;
  localparam logic [7:0] A_ANYBSY  = 8'h1C;
  localparam logic [7:0] A_WMASK   = 8'h24;
  localparam logic [7:0] A_WRAW    = 8'h28;
  localparam logic [7:0] A_WSTAT   = 8'h2C;
  localparam logic [7:0] A_PD_A    = 8'h30;
  localparam logic [7:0] A_PD_B    = 8'h34;
  localparam logic [7:0] A_IDLE    = 8'h3C;
  localparam logic [7:0] A_MBOX_A  = 8'h68;
  localparam logic [7:0] A_CFG_WD  = 8'h70;
  localparam logic [7:0] A_CFG_RD  = 8'h74;
  localparam logic [7:0] A_MBOX_B  = 8'h78;
endpackage

// File: rtl/pwrc_cfg_rom.sv
module pwrc_cfg_rom #(
  parameter int CFG_WORDS = 16,
  localparam int IDX_W = $clog2(CFG_WORDS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      data_o
);
  logic [31:0] tbl [CFG_WORDS];

  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_word
    // voltage in mV above bit 20, frequency code below
    assign tbl[k] = (32'(900 + 10 * k) << 20) | 32'(50000 + 5000 * k);
  end

  assign data_o = tbl[idx_i];
endmodule

// File: rtl/pwrc_engine.sv
module pwrc_engine
  import pwrc_pkg::*;
#(
  parameter int LATENCY = 16,
  localparam int CNT_W = $clog2(LATENCY + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  req_t        type_i,
  input  logic        fail_i,
  input  logic [31:0] data_i,
  output logic        busy_o,
  output logic        done_o,
  output req_t        type_o,
  output logic        err_o,
  output logic [31:0] data_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, fail_q;
  req_t             type_q;
  logic [31:0]      data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
      type_q <= REQ_LVL_A;
      data_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LATENCY - 1);
      fail_q <= fail_i;
      type_q <= type_i;
      data_q <= data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign type_o = type_q;
  assign err_o  = fail_q;
  assign data_o = data_q;
endmodule

// File: rtl/pwrc_ctrl.sv
module pwrc_ctrl
  import pwrc_pkg::*;
#(
  parameter int          LATENCY   = 16,
  parameter int          NUM_OPP   = 5,
  parameter int          N_CPU     = 2,
  parameter logic [3:0]  CFG_FUNC  = 4'd6,
  parameter logic [19:0] CFG_BASE  = 20'h304,
  parameter int          CFG_WORDS = 16,
  localparam int LVL_W     = 3,
  localparam int CFG_IDX_W = $clog2(CFG_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [11:0]      wake_raw_i,
  input  logic [N_CPU-1:0] wfi_a_i,
  input  logic [N_CPU-1:0] wfi_b_i,
  output logic             irq_o,
  output logic [11:0]      wake_mask_o,
  output logic             pd_en_a_o,
  output logic             pd_en_b_o
);
  logic [LVL_W-1:0] lvl_a_q, lvl_b_q;
  logic [31:0]      cmd_q, cfg_wd_q, cfg_rd_q;
  logic [ST_W-1:0]  status_q, st_set;
  logic [11:0]      wmask_q;
  logic             pd_a_q, pd_b_q;
  logic [31:0]      mbox_a_q [N_CPU];
  logic [31:0]      mbox_b_q [N_CPU];

  // request decode
  logic        req_any, req_fail, eng_start, reject;
  req_t        req_type;
  logic [19:0] cmd_off;
  logic [CFG_IDX_W-1:0] cfg_idx;
  logic [31:0] rom_data, req_data;

  always_comb begin
    req_any  = 1'b0;
    req_type = REQ_LVL_A;
    req_fail = 1'b0;
    req_data = wdata_i;
    cmd_off  = wdata_i[19:0];
    cfg_idx  = CFG_IDX_W'(cmd_off - CFG_BASE);
    if (we_i) begin
      unique case (addr_i)
        A_LVL_A: begin
          req_any  = 1'b1;
          req_type = REQ_LVL_A;
          req_fail = wdata_i >= 32'(NUM_OPP);
        end
        A_LVL_B: begin
          req_any  = 1'b1;
          req_type = REQ_LVL_B;
          req_fail = wdata_i >= 32'(NUM_OPP);
        end
        A_CMD: begin
          req_any  = wdata_i[31];
          req_type = REQ_CFG;
          req_fail = (wdata_i[23:20] != CFG_FUNC) || (cmd_off < CFG_BASE) ||
                     (cmd_off >= CFG_BASE + 20'(CFG_WORDS));
          req_data = rom_data;
        end
        default: ;
      endcase
    end
  end

  pwrc_cfg_rom #(.CFG_WORDS(CFG_WORDS)) u_rom (
    .idx_i  (cfg_idx),
    .data_o (rom_data)
  );

  logic        eng_busy, eng_done, eng_err;
  req_t        eng_type;
  logic [31:0] eng_data;

  assign eng_start = req_any && !eng_busy;
  assign reject    = req_any && eng_busy;

  pwrc_engine #(.LATENCY(LATENCY)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .type_i  (req_type),
    .fail_i  (req_fail),
    .data_i  (req_data),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .type_o  (eng_type),
    .err_o   (eng_err),
    .data_o  (eng_data)
  );

  // one completion/error pair per request type, 4-bit stride
  for (genvar t = 0; t < N_REQ; t++) begin : g_st
    logic fin_t;
    assign fin_t            = eng_done && (eng_type == req_t'(t));
    assign st_set[4*t]      = fin_t && !eng_err;
    assign st_set[4*t+1]    = (fin_t && eng_err) || (reject && (req_type == req_t'(t)));
    assign st_set[4*t+3:4*t+2] = 2'b00;
  end

  logic stat_rd;
  assign stat_rd = re_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      lvl_a_q  <= '0;
      lvl_b_q  <= '0;
      cfg_rd_q <= '0;
    end else begin
      status_q <= (stat_rd ? '0 : status_q) | st_set;
      if (eng_done && !eng_err) begin
        unique case (eng_type)
          REQ_LVL_A: lvl_a_q  <= eng_data[LVL_W-1:0];
          REQ_LVL_B: lvl_b_q  <= eng_data[LVL_W-1:0];
          default:   cfg_rd_q <= eng_data;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      cfg_wd_q <= '0;
      wmask_q  <= '0;
      pd_a_q   <= 1'b0;
      pd_b_q   <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_CMD:    cmd_q    <= wdata_i;
        A_CFG_WD: cfg_wd_q <= wdata_i;
        A_WMASK:  wmask_q  <= wdata_i[11:0];
        A_PD_A:   pd_a_q   <= wdata_i[0];
        A_PD_B:   pd_b_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < N_CPU; n++) begin : g_mbox
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mbox_a_q[n] <= '0;
        mbox_b_q[n] <= '0;
      end else if (we_i) begin
        if (addr_i == A_MBOX_A + 8'(4 * n)) mbox_a_q[n] <= wdata_i;
        if (addr_i == A_MBOX_B + 8'(4 * n)) mbox_b_q[n] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LVL_A:   rdata_o = 32'(lvl_a_q);
      A_LVL_B:   rdata_o = 32'(lvl_b_q);
      A_BSY_A:   rdata_o = 32'(eng_busy && eng_type == REQ_LVL_A);
      A_BSY_B:   rdata_o = 32'(eng_busy && eng_type == REQ_LVL_B);
      A_BSY_CMD: rdata_o = 32'(eng_busy && eng_type == REQ_CFG);
      A_ANYBSY:  rdata_o = 32'(eng_busy);
      A_CMD:     rdata_o = cmd_q;
      A_STAT:    rdata_o = 32'(status_q);
      A_WMASK:   rdata_o = 32'(wmask_q);
      A_WRAW:    rdata_o = 32'(wake_raw_i);
      A_WSTAT:   rdata_o = 32'(wake_raw_i & wmask_q);
      A_PD_A:    rdata_o = 32'(pd_a_q);
      A_PD_B:    rdata_o = 32'(pd_b_q);
      A_IDLE: begin
        rdata_o[N_CPU-1:0]   = wfi_a_i;
        rdata_o[3 +: N_CPU]  = wfi_b_i;
      end
      A_CFG_WD:  rdata_o = cfg_wd_q;
      A_CFG_RD:  rdata_o = cfg_rd_q;
      default: ;
    endcase
    for (int n = 0; n < N_CPU; n++) begin
      if (addr_i == A_MBOX_A + 8'(4 * n)) rdata_o = mbox_a_q[n];
      if (addr_i == A_MBOX_B + 8'(4 * n)) rdata_o = mbox_b_q[n];
    end
  end

  assign irq_o       = |status_q;
  assign wake_mask_o = wmask_q;
  assign pd_en_a_o   = pd_a_q;
  assign pd_en_b_o   = pd_b_q;
endmodule

// File: rtl/pwrc_ctrl_chk.sv
module pwrc_ctrl_chk #(
  parameter int LATENCY = 16,
  parameter int LVL_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             re_i,
  input logic [7:0]       addr_i,
  input logic             irq_o,
  input logic             busy_i,
  input logic             done_i,
  input logic             err_i,
  input logic [1:0]       type_i,
  input logic [LVL_W-1:0] lvl_a_i,
  input logic [31:0]      cfg_rd_i,
  input logic [11:0]      st_set_i
);
  logic [31:0] bcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt <= '0;
    else if (busy_i) bcnt <= bcnt + 1;
    else             bcnt <= '0;
  end

  a_r2_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (bcnt < 32'(LATENCY)));

  a_r2_done_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (bcnt == 32'(LATENCY - 1)));

  a_r3_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_a_i) |-> $past(done_i && !err_i && type_i == 2'd0));

  a_r5_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_rd_i) |-> $past(done_i && !err_i && type_i == 2'd2));

  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i || (we_i && busy_i)));

  a_r6_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 8'h18 && st_set_i == '0) |=> !irq_o);

  a_r7_run_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> (busy_i && $stable(type_i)));
endmodule

bind pwrc_ctrl pwrc_ctrl_chk #(.LATENCY(LATENCY), .LVL_W(LVL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .addr_i   (addr_i),
  .irq_o    (irq_o),
  .busy_i   (eng_busy),
  .done_i   (eng_done),
  .err_i    (eng_err),
  .type_i   (eng_type),
  .lvl_a_i  (lvl_a_q),
  .cfg_rd_i (cfg_rd_q),
  .st_set_i (st_set)
);

// File: tb/pwrc_ctrl_test.sv
module pwrc_ctrl_test;
  localparam int LAT  = 16;
  localparam int NOPP = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [11:0] wake_raw_i = '0;
  logic [1:0]  wfi_a_i = '0, wfi_b_i = '0;
  logic        irq_o, pd_en_a_o, pd_en_b_o;
  logic [11:0] wake_mask_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  pwrc_ctrl uut (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o,
    .wake_raw_i, .wfi_a_i, .wfi_b_i, .irq_o, .wake_mask_o,
    .pd_en_a_o, .pd_en_b_o
  );

  function automatic logic [31:0] cfgval(int k);
    return (32'(900 + 10 * k) << 20) | 32'(50000 + 5000 * k);
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // each task starts and ends at a negedge and spans one posedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    re_i = 1'b1; addr_i = a;
    #1 v = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // {req, addr, wdata, expected readback}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {4'd9,  8'h24, 32'hFFFF_FFFF, 32'h0000_0FFF},  // R9 mask width
    {4'd9,  8'h24, 32'h0000_0C21, 32'h0000_0C21},  // R9
    {4'd11, 8'h68, 32'hDEAD_BEE0, 32'hDEAD_BEE0},  // R11 mailbox A0
    {4'd11, 8'h6C, 32'h1234_5678, 32'h1234_5678},  // R11 mailbox A1
    {4'd11, 8'h78, 32'hCAFE_0004, 32'hCAFE_0004},  // R11 mailbox B0
    {4'd11, 8'h7C, 32'h0BAD_F00C, 32'h0BAD_F00C},  // R11 mailbox B1
    {4'd11, 8'h30, 32'hFFFF_FFFF, 32'h0000_0001},  // R11 pd A
    {4'd11, 8'h34, 32'h0000_0000, 32'h0000_0000},  // R11 pd B
    {4'd12, 8'h70, 32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R12 cfg write data
    {4'd12, 8'h74, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 read-only
    {4'd12, 8'h3C, 32'hFFFF_FFFF, 32'h0000_0000},  // R12 read-only
    {4'd12, 8'h60, 32'hFFFF_FFFF, 32'h0000_0000}   // R12 unmapped
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1", "irq", 32'(irq_o), 0);
    chk("R1", "pd", {30'd0, pd_en_a_o, pd_en_b_o}, 0);
    rd(8'h00, v); chk("R1", "lvl A", v, 0);
    rd(8'h18, v); chk("R1", "status", v, 0);
    rd(8'h24, v); chk("R1", "wake mask", v, 0);
    rd(8'h68, v); chk("R1", "mailbox", v, 0);
    rd(8'h74, v); chk("R1", "cfg rdata", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      n_run++;
      if (v !== VEC[i][31:0]) begin
        n_fail++;
        $display("FAIL R%0d row %0d: actual %h expected %h", VEC[i][75:72], i, v, VEC[i][31:0]);
      end
    end
    chk("R9", "wake_mask_o", 32'(wake_mask_o), 32'h0C21);
    chk("R11", "pd outputs", {30'd0, pd_en_a_o, pd_en_b_o}, 32'h2);
    wake_raw_i = 12'hFFF;
    rd(8'h28, v); chk("R9", "wake raw", v, 32'hFFF);
    rd(8'h2C, v); chk("R9", "wake masked", v, 32'hC21);
    wfi_a_i = 2'b10; wfi_b_i = 2'b01;
    rd(8'h3C, v); chk("R10", "idle map", v, 32'h0A);

    // R2 / R8 cluster A level change with exact timing
    wr(8'h00, 2);
    rd(8'h04, v); chk("R8", "busy A", v, 1);
    rd(8'h0C, v); chk("R8", "busy B", v, 0);
    rd(8'h1C, v); chk("R8", "any busy", v, 1);
    rd(8'h00, v); chk("R2", "lvl A before", v, 0);
    cyc(LAT - 1 - 4);
    chk("R2", "irq at LAT-1", 32'(irq_o), 0);
    cyc(1);
    chk("R6", "irq at LAT", 32'(irq_o), 1);
    rd(8'h18, v); chk("R2", "status A done", v, 32'h1);
    chk("R6", "irq after read", 32'(irq_o), 0);
    rd(8'h00, v); chk("R2", "lvl A after", v, 2);
    rd(8'h1C, v); chk("R8", "idle after", v, 0);

    // R3 boundary on cluster B
    wr(8'h08, NOPP - 1);
    cyc(LAT);
    rd(8'h18, v); chk("R3", "last valid index", v, 32'h10);
    rd(8'h08, v); chk("R3", "lvl B valid", v, NOPP - 1);
    wr(8'h08, NOPP);
    cyc(LAT);
    rd(8'h18, v); chk("R3", "index too high", v, 32'h20);
    rd(8'h08, v); chk("R3", "lvl B kept", v, NOPP - 1);

    // R4 config reads
    wr(8'h10, 32'h8060_0307);
    rd(8'h14, v); chk("R8", "busy cmd", v, 1);
    cyc(LAT - 1);
    rd(8'h18, v); chk("R4", "cfg done", v, 32'h100);
    rd(8'h74, v); chk("R4", "cfg word 3", v, cfgval(3));
    rd(8'h10, v); chk("R4", "cmd readback", v, 32'h8060_0307);
    wr(8'h10, 32'h8060_0313);
    cyc(LAT);
    rd(8'h18, v); chk("R4", "last word done", v, 32'h100);
    rd(8'h74, v); chk("R4", "cfg word 15", v, cfgval(15));
    wr(8'h10, 32'h8060_0304);
    cyc(LAT);
    rd(8'h18, v); chk("R4", "first word done", v, 32'h100);
    rd(8'h74, v); chk("R4", "cfg word 0", v, cfgval(0));

    // R5 bad commands
    wr(8'h10, 32'h8060_0303);
    cyc(LAT);
    rd(8'h18, v); chk("R5", "offset below", v, 32'h200);
    wr(8'h10, 32'h8060_0314);
    cyc(LAT);
    rd(8'h18, v); chk("R5", "offset above", v, 32'h200);
    wr(8'h10, 32'h8050_0305);
    cyc(LAT);
    rd(8'h18, v); chk("R5", "bad function", v, 32'h200);
    rd(8'h74, v); chk("R5", "rdata kept", v, cfgval(0));
    wr(8'h10, 32'h0060_0305);
    cyc(LAT + 2);
    chk("R5", "no start irq", 32'(irq_o), 0);
    rd(8'h74, v); chk("R5", "no start rdata", v, cfgval(0));

    // R7 rejection while busy
    wr(8'h00, 1);
    wr(8'h00, 3);
    chk("R7", "reject irq", 32'(irq_o), 1);
    wr(8'h10, 32'h8060_0305);
    cyc(LAT - 2);
    rd(8'h18, v); chk("R7", "reject + done", v, 32'h203);
    rd(8'h00, v); chk("R7", "running level kept", v, 1);
    rd(8'h74, v); chk("R7", "rdata untouched", v, cfgval(0));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule